// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a board-level supervisor. It watches a power-fail flag that is already synchronous to its clock. It also watches two external reset request lines, which are active low and asynchronous. Its output is a pull-low enable for an open-drain reset pin. A value of 1 means the pin is pulled low. A value of 0 means the pin is let go. The block has no way to drive the pin high.

While the supply is bad, the reset stays asserted. Once the supply is good again, the reset is held for a fixed number of millisecond ticks and is then released. The ticks arrive on a one-cycle enable input. Either request line can start a pulse of the same length. While the reset is asserted, both request lines are ignored. The default hold is 100 ticks, which sits inside a 40 to 200 ms window at a 1 kHz tick rate. A synchronous reset of the block acts like a fresh power-up.

Top module: `rstgen_top`

## Requirements
- R1: While `pwr_fail` is 1 at a clock edge, `rst_drive_low` is 1 after that edge. Ticks on `ms_tick` have no effect while `pwr_fail` is 1.
- R2: After `pwr_fail` returns to 0, `rst_drive_low` stays 1 until `HOLD_MS` ticks have been counted. A tick in the same cycle that `pwr_fail` drops is not counted. The output goes to 0 on the edge that samples the `HOLD_MS`-th tick. If no ticks arrive, the output stays 1.
- R3: While released, a high-to-low change on `req_a_n` raises `rst_drive_low` after the third clock edge that samples the new level. Two edges of synchroniser come first, then one edge of state update.
- R4: `req_b_n` starts a pulse in the same way as `req_a_n`, independently of it.
- R5: A pulse started by a request line lasts `HOLD_MS` ticks, the same length as the hold after a power cycle.
- R6: While `rst_drive_low` is 1, falling edges on either request line are ignored and do not lengthen the pulse. A line still held low when the output releases does not start a new pulse.
- R7: If `pwr_fail` rises during a hold that a request started, the count is reloaded. The full `HOLD_MS` ticks are then counted after `pwr_fail` falls.
- R8: While `rst_n` is 0, `rst_drive_low` is 1 after each edge. After `rst_n` returns to 1, the block counts a full `HOLD_MS`-tick hold before it releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset. Acts as a power-up. |
| pwr_fail | input | 1 | Supply below trip point (synchronous, active high) |
| req_a_n | input | 1 | External reset request A (asynchronous, active low) |
| req_b_n | input | 1 | External reset request B (asynchronous, active low) |
| ms_tick | input | 1 | One-cycle millisecond tick enable |
| rst_drive_low | output | 1 | 1 = pull the reset pin low, 0 = release it |

## Verification
The bench builds the block with `HOLD_MS` = 5 and gives a tick every fourth clock. A whole hold therefore lasts about twenty cycles. This makes it practical to run several pulses in one run: power cycles, request pulses, requests that overlap a pulse, and a power failure inside a request pulse. The 2-stage synchroniser default is kept, so the three-edge request latency is checked as built. Stopping the ticks for a while shows that release depends only on counted ticks.

// File: rtl/rstgen_pkg.sv
// Shared types for the supervisory reset pulse generator.
package rstgen_pkg;

    // Controller states: supply bad, timed hold, output released.
    typedef enum logic [1:0] {
        ST_PFAIL = 2'd0,
        ST_HOLD  = 2'd1,
        ST_IDLE  = 2'd2
    } rst_state_e;

endpackage

// File: rtl/rstgen_sync.sv
// Multi-flop synchroniser for one asynchronous input bit.
// Assumes: STAGES >= 2; flops reset to RESET_VAL on a synchronous active-low reset.
module rstgen_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rstgen_fall_det.sv
// High-to-low edge detector on a synchronised active-low request.
// Assumes: the input is already in the clk domain; the idle level is 1.
module rstgen_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);

    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= lvl;
        end
    end

    assign fall = prev_q & ~lvl;

endmodule

// File: rtl/rstgen_hold_ctr.sv
// Down-counter of millisecond ticks for the reset hold interval.
// Assumes: HOLD_MS >= 1; load has priority over counting;
// expired pulses on the tick that ends the interval.
module rstgen_hold_ctr #(
    parameter int HOLD_MS = 100,
    parameter int CW      = $clog2(HOLD_MS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic          tick,
    output logic          expired,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_MS);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_q;

    // Reload on request, else count ticks down while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LOAD_VAL;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired = run && tick && (cnt_q == ONE);
    assign cnt     = cnt_q;

endmodule

// File: rtl/rstgen_top.sv
// Supervisory reset pulse generator.
// Drives a pull-low enable for an open-drain reset. Power-fail forces and
// holds reset; recovery or a request on either input gives a timed pulse.
// Assumes: pwr_fail is synchronous to clk; request inputs are asynchronous
// and active low; ms_tick is a one-cycle enable; rst_n is synchronous.
module rstgen_top #(
    parameter int HOLD_MS     = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail,
    input  logic req_a_n,
    input  logic req_b_n,
    input  logic ms_tick,
    output logic rst_drive_low
);

    import rstgen_pkg::*;

    localparam int NUM_REQ = 2;
    localparam int CW      = $clog2(HOLD_MS + 1);

    logic [NUM_REQ-1:0] req_raw_n;
    logic [NUM_REQ-1:0] req_sync_n;
    logic [NUM_REQ-1:0] req_fall;
    logic               fall_any;
    rst_state_e         state_q;
    rst_state_e         state_d;
    logic               ctr_load;
    logic               ctr_run;
    logic               ctr_expired;
    logic [CW-1:0]      ctr_val;
    logic               drive_q;

    assign req_raw_n = {req_b_n, req_a_n};

    // One synchroniser and edge detector per request channel.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        rstgen_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(1'b1)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (req_raw_n[i]),
            .q    (req_sync_n[i])
        );

        rstgen_fall_det u_fall (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (req_sync_n[i]),
            .fall (req_fall[i])
        );
    end

    assign fall_any = |req_fall;

    // Next-state choice: power failure wins, requests count only when released.
    always_comb begin
        state_d = state_q;
        if (pwr_fail) begin
            state_d = ST_PFAIL;
        end else begin
            unique case (state_q)
                ST_PFAIL: state_d = ST_HOLD;
                ST_HOLD:  if (ctr_expired) state_d = ST_IDLE;
                ST_IDLE:  if (fall_any) state_d = ST_HOLD;
                default:  state_d = ST_HOLD;
            endcase
        end
    end

    assign ctr_load = pwr_fail || (state_q == ST_PFAIL) ||
                      ((state_q == ST_IDLE) && fall_any);
    assign ctr_run  = (state_q == ST_HOLD) && !pwr_fail;

    rstgen_hold_ctr #(
        .HOLD_MS(HOLD_MS),
        .CW     (CW)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctr_load),
        .run    (ctr_run),
        .tick   (ms_tick),
        .expired(ctr_expired),
        .cnt    (ctr_val)
    );

    // State register; reset behaves as a fresh power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered pull-low enable, free of decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b1;
        end else begin
            drive_q <= (state_d != ST_IDLE);
        end
    end

    assign rst_drive_low = drive_q;

endmodule

// File: rtl/rstgen_chk.sv
// Property checker for rstgen_top, attached by bind.
// Assumes: it sees the controller state, hold count and combined request edge.
module rstgen_chk #(
    parameter int HOLD_MS = 100,
    parameter int CW      = $clog2(HOLD_MS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwr_fail,
    input logic                   ms_tick,
    input logic                   rst_drive_low,
    input logic                   fall_any,
    input rstgen_pkg::rst_state_e state_q,
    input logic [CW-1:0]          ctr_val
);

    import rstgen_pkg::*;

    AST_PF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> rst_drive_low);  // R1

    AST_RELEASE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_drive_low && !ms_tick) |=> rst_drive_low);  // R2

    AST_REQ_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_drive_low && fall_any && !pwr_fail) |=> rst_drive_low);  // R3

    AST_HOLD_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !pwr_fail) |=> (state_q != ST_HOLD || ctr_val <= $past(ctr_val)));  // R6

    AST_PF_RELOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PFAIL) |-> (ctr_val == CW'(HOLD_MS)));  // R7

    AST_HOLD_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (ctr_val != '0 && ctr_val <= CW'(HOLD_MS)));  // R5

endmodule

bind rstgen_top rstgen_chk #(
    .HOLD_MS(HOLD_MS),
    .CW     (CW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_fail     (pwr_fail),
    .ms_tick      (ms_tick),
    .rst_drive_low(rst_drive_low),
    .fall_any     (fall_any),
    .state_q      (state_q),
    .ctr_val      (ctr_val)
);

// File: tb/sim_rstgen_top.sv
// Bench for rstgen_top: behavioural reference model compared every clock,
// plus directed checks at chosen cycles.
module sim_rstgen_top;

    localparam int HOLD     = 5;
    localparam int TICK_DIV = 4;
    localparam int HOLD_MIN = (HOLD - 1) * TICK_DIV + 1;
    localparam int HOLD_MAX = HOLD * TICK_DIV + 1;

    logic clk      = 1'b0;
    logic rst_n    = 1'b0;
    logic pwr_fail = 1'b0;
    logic req_a_n  = 1'b1;
    logic req_b_n  = 1'b1;
    logic ms_tick  = 1'b0;
    logic rst_drive_low;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R8";
    bit    cmp_on = 1'b0;
    bit    tick_en = 1'b1;
    int    tdiv   = 0;

    rstgen_top #(.HOLD_MS(HOLD), .SYNC_STAGES(2)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_fail     (pwr_fail),
        .req_a_n      (req_a_n),
        .req_b_n      (req_b_n),
        .ms_tick      (ms_tick),
        .rst_drive_low(rst_drive_low)
    );

    always #5 clk = ~clk;

    // Tick source: one cycle in every TICK_DIV, changed away from the rising edge.
    always @(negedge clk) begin
        if (tick_en && tdiv == TICK_DIV - 1) begin
            ms_tick <= 1'b1;
            tdiv    <= 0;
        end else begin
            ms_tick <= 1'b0;
            tdiv    <= (tdiv + 1) % TICK_DIV;
        end
    end

    // Reference model: 0 = supply bad, 1 = holding, 2 = released.
    int m_st  = 1;
    int m_cnt = HOLD;
    bit ha[$] = '{1'b1, 1'b1, 1'b1};
    bit hb[$] = '{1'b1, 1'b1, 1'b1};

    always @(posedge clk) begin
        bit fa, fb;
        if (!rst_n) begin
            m_st  = 1;
            m_cnt = HOLD;
            ha = '{1'b1, 1'b1, 1'b1};
            hb = '{1'b1, 1'b1, 1'b1};
        end else begin
            fa = ha[0] && !ha[1];
            fb = hb[0] && !hb[1];
            if (pwr_fail) begin
                m_st = 0; m_cnt = HOLD;
            end else if (m_st == 0) begin
                m_st = 1; m_cnt = HOLD;
            end else if (m_st == 1) begin
                if (ms_tick) begin
                    if (m_cnt == 1) m_st = 2;
                    else m_cnt = m_cnt - 1;
                end
            end else if (fa || fb) begin
                m_st = 1; m_cnt = HOLD;
            end
            ha.push_back(req_a_n); void'(ha.pop_front());
            hb.push_back(req_b_n); void'(hb.pop_front());
        end
    end

    task automatic chk(string r, bit exp);
        checks++;
        if (rst_drive_low !== exp) begin
            fails++;
            $display("FAIL %s: rst_drive_low=%0b expected %0b at %0t", r, rst_drive_low, exp, $time);
        end
    endtask

    // Compare against the model on every clock, between edges.
    always @(negedge clk) begin
        if (cmp_on) chk(tag, (m_st != 2));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Pulse a request line low for three cycles; check its three-edge latency.
    task automatic req_pulse(bit use_b, string r);
        if (use_b) req_b_n = 1'b0; else req_a_n = 1'b0;
        cyc(2);
        chk(r, 1'b0);
        cyc(1);
        chk(r, 1'b1);
        if (use_b) req_b_n = 1'b1; else req_a_n = 1'b1;
    endtask

    initial begin
        // R8: reset acts as power-up
        cyc(3);
        chk("R8", 1'b1);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cyc(2);
        chk("R8", 1'b1);
        cyc(HOLD_MAX + 3);
        chk("R8", 1'b0);

        // R3 and R5: request A gives a full-length pulse
        tag = "R3";
        req_pulse(1'b0, "R3");
        tag = "R5";
        cyc(HOLD_MIN - 2);
        chk("R5", 1'b1);
        cyc(5);
        chk("R5", 1'b0);

        // R4: request B works the same way
        tag = "R4";
        req_pulse(1'b1, "R4");
        cyc(HOLD_MIN - 2);
        chk("R4", 1'b1);
        cyc(5);
        chk("R4", 1'b0);

        // R6: requests during a pulse are ignored; a held-low line does not retrigger
        tag = "R6";
        req_pulse(1'b0, "R6");
        cyc(4);
        req_b_n = 1'b0;
        req_a_n = 1'b0;
        cyc(3);
        req_a_n = 1'b1;
        cyc(HOLD_MAX - 7);
        chk("R6", 1'b0);
        cyc(30);
        chk("R6", 1'b0);
        req_b_n = 1'b1;
        cyc(6);
        chk("R6", 1'b0);

        // R1 and R2: power failure forces reset, ticks ignored, then timed hold
        tag = "R1";
        pwr_fail = 1'b1;
        cyc(1);
        chk("R1", 1'b1);
        cyc(30);
        chk("R1", 1'b1);
        tag = "R2";
        pwr_fail = 1'b0;
        cyc(HOLD_MIN - 1);
        chk("R2", 1'b1);
        cyc(6);
        chk("R2", 1'b0);

        // R2: no ticks means no release
        tick_en = 1'b0;
        req_pulse(1'b0, "R2");
        cyc(50);
        chk("R2", 1'b1);
        tick_en = 1'b1;
        cyc(HOLD_MAX + 4);
        chk("R2", 1'b0);

        // R7: power failure inside a request pulse reloads the hold
        tag = "R7";
        req_pulse(1'b1, "R7");
        cyc(10);
        pwr_fail = 1'b1;
        cyc(5);
        chk("R7", 1'b1);
        pwr_fail = 1'b0;
        cyc(HOLD_MIN - 1);
        chk("R7", 1'b1);
        cyc(6);
        chk("R7", 1'b0);

        cmp_on = 1'b0;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

endmodule